// File: doc/BRIEF.md
# Periodic Timebase Interrupt Generator

This block produces a periodic interrupt from a slow counting clock. It passes counting ticks through a fixed binary prescaler and then a binary divider chain. One of eight tap bits of the combined counter is picked by a 3-bit rate field. Each rising edge of the chosen tap bit sets a sticky status flag. The interrupt request is that flag gated by an interrupt-enable input. Software clears the flag by writing a one to an acknowledge bit.

The block works in a single system clock domain. The internal and external counting sources reach it as one-cycle tick strobes that are synchronous to `clk`. A select input decides which of the two strobes advances the counter. Clearing the enable input holds the whole counter at zero. Because the tap event is a 0-to-1 transition of a counter bit, the first flag after enabling comes at half the selected period, and every later flag comes at the full period. While the stop-mode input is high, counting continues only if the stop-run configuration bit is set. Otherwise the counter is frozen, and it resumes from the same value when stop mode ends.

Top module: `timebase_irq`

## Requirements
- R1: While `enable` is 0, the counter is held at zero. No new flag is raised while `enable` is 0, whatever the ticks do.
- R2: The rate field selects the division ratio 2^E. With P = PRE_BITS and C = CHAIN_BITS, E is P+3+i for index i = 0..4, P+11 for index 5, P+13 for index 6, and P+C for index 7. With the defaults P = 7 and C = 15 this gives 1024, 2048, 4096, 8192, 16384, 262144, 1048576 and 4194304 ticks.
- R3: After `enable` rises from a zero counter, the first flag is set by the edge that applies tick number 2^(E-1), which is half the selected period.
- R4: After the first flag, the flag is set again once every 2^E counted ticks.
- R5: `irq` is high exactly when `flag` is 1 and `irqEn` is 1.
- R6: A cycle with `ackWr`=1 and `ackVal`=1 clears `flag` on the next edge. A cycle with `ackWr`=1 and `ackVal`=0 leaves `flag` unchanged.
- R7: If a tap event and a clearing acknowledge happen in the same cycle, `flag` ends up set.
- R8: When `extSel` is 1, only `extTick` advances the counter. When `extSel` is 0, only `intTick` advances it.
- R9: While `stopMode` is 1 and `stopRunEn` is 0, the counter is frozen and no flag is raised. When `stopRunEn` is 1, counting continues during stop mode.
- R10: A synchronous reset clears `flag` and the counter, so `flag` and `irq` read 0 after reset.
- R11: A change of the rate field while counting takes effect at the next rising edge of the newly selected tap bit, and the counter is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| intTick | input | 1 | Tick strobe from the internal counting source |
| extTick | input | 1 | Tick strobe from the external counting source |
| extSel | input | 1 | 1 selects the external tick, 0 selects the internal tick |
| enable | input | 1 | Run enable; 0 holds the counter at zero |
| rateSel | input | 3 | Tap index 0..7, in ascending ratio order |
| irqEn | input | 1 | Interrupt enable |
| ackWr | input | 1 | Write strobe for the acknowledge bit |
| ackVal | input | 1 | Value written; 1 clears the flag |
| stopMode | input | 1 | High while the chip is in stop mode |
| stopRunEn | input | 1 | Configuration bit that allows counting during stop mode |
| flag | output | 1 | Sticky periodic event flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the tick inputs are already synchronous single-cycle strobes in the `clk` domain. They also assume that an acknowledge is a single-cycle `ackWr` pulse whose `ackVal` is valid in that same cycle. The bench drives every input only at the falling edge, one cycle at a time, so ticks, acknowledges and rate changes never meet a clock edge mid-change. Random stimulus keeps the rate field on the short taps so that many periods fit in the run. The long taps are reached only by directed first-event measurements that start from a zeroed counter.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  localparam int NUM_TAPS = 8;
  localparam int SEL_W    = $clog2(NUM_TAPS);

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;   // advance the counter by one this cycle
    logic clearAll;  // hold the counter at zero
  } ctrlStrobes_t;

  // Division exponent for a tap index: ratio = 2**exponent
  function automatic int tapExponent(input int idx, input int preBits, input int chainBits);
    int e;
    if (idx < 5)       e = preBits + 3 + idx;
    else if (idx == 5) e = preBits + 11;
    else if (idx == 6) e = preBits + 13;
    else               e = preBits + chainBits;
    return e;
  endfunction

endpackage

// File: rtl/timebase_divider.sv
module timebase_divider
  import timebase_pkg::*;
#(
  parameter int PRE_BITS   = 7,
  parameter int CHAIN_BITS = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [SEL_W-1:0] rateSel,
  output logic             tapHit
);

  localparam int TOTAL = PRE_BITS + CHAIN_BITS;

  logic [TOTAL-1:0]    cnt;
  logic [TOTAL-1:0]    cntNext;
  logic [NUM_TAPS-1:0] edgeAt;

  assign cntNext = cnt + {{(TOTAL-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) cnt <= '0;
    else if (strobes.countEn)    cnt <= cntNext;
  end

  // Rising-edge detector on each selectable tap bit
  for (genvar i = 0; i < NUM_TAPS; i++) begin : gTap
    localparam int TAP_BIT = tapExponent(i, PRE_BITS, CHAIN_BITS) - 1;
    assign edgeAt[i] = ~cnt[TAP_BIT] & cntNext[TAP_BIT];
  end

  assign tapHit = strobes.countEn & ~strobes.clearAll & edgeAt[rateSel];

  // R1: a clear request leaves the counter at zero
  assert_held_zero_R1: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAll |=> (cnt == '0));

  // R9: with no count strobe the counter does not move
  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!strobes.countEn && !strobes.clearAll) |=> $stable(cnt));

endmodule

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         intTick,
  input  logic         extTick,
  input  logic         extSel,
  input  logic         enable,
  input  logic         stopMode,
  input  logic         stopRunEn,
  input  logic         tapHit,
  input  logic         ackWr,
  input  logic         ackVal,
  input  logic         irqEn,
  output ctrlStrobes_t strobes,
  output logic         flag,
  output logic         irq
);

  logic selTick;
  logic stopHold;
  logic ackClear;

  assign selTick  = extSel ? extTick : intTick;
  assign stopHold = stopMode & ~stopRunEn;
  assign ackClear = ackWr & ackVal;

  always_comb begin
    strobes.clearAll = ~enable;
    strobes.countEn  = enable & selTick & ~stopHold;
  end

  // A tap event takes priority over a clearing acknowledge
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (tapHit)   flag <= 1'b1;
    else if (ackClear) flag <= 1'b0;
  end

  assign irq = flag & irqEn;

  // R3: a tap event raises the flag on the next edge
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    tapHit |=> flag);

  // R6: writing one clears the flag, writing zero keeps it
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ackWr && ackVal && !tapHit) |=> !flag);
  assert_ack_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (ackWr && !ackVal && flag) |=> flag);

  // R7: a simultaneous event wins over the acknowledge
  assert_ack_race_R7: assert property (@(posedge clk) disable iff (rst)
    (tapHit && ackWr && ackVal) |=> flag);

  // R1: the divider reports no event while disabled
  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !tapHit);

  // R9: no event while stop mode freezes the count
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (stopMode && !stopRunEn) |-> !tapHit);

  // R5: a request needs both the flag and the enable
  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && irqEn));

endmodule

// File: rtl/timebase_irq.sv
module timebase_irq
  import timebase_pkg::*;
#(
  parameter int PRE_BITS   = 7,
  parameter int CHAIN_BITS = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       intTick,
  input  logic       extTick,
  input  logic       extSel,
  input  logic       enable,
  input  logic [2:0] rateSel,
  input  logic       irqEn,
  input  logic       ackWr,
  input  logic       ackVal,
  input  logic       stopMode,
  input  logic       stopRunEn,
  output logic       flag,
  output logic       irq
);

  ctrlStrobes_t strobes;
  logic         tapHit;

  timebase_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .intTick   (intTick),
    .extTick   (extTick),
    .extSel    (extSel),
    .enable    (enable),
    .stopMode  (stopMode),
    .stopRunEn (stopRunEn),
    .tapHit    (tapHit),
    .ackWr     (ackWr),
    .ackVal    (ackVal),
    .irqEn     (irqEn),
    .strobes   (strobes),
    .flag      (flag),
    .irq       (irq)
  );

  timebase_divider #(
    .PRE_BITS   (PRE_BITS),
    .CHAIN_BITS (CHAIN_BITS)
  ) uDiv (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rateSel (rateSel),
    .tapHit  (tapHit)
  );

endmodule

// File: tb/timebase_irq_test.sv
module timebase_irq_test;

  localparam int P = 1;
  localparam int C = 15;
  localparam int TOT = P + C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic intTick = 0, extTick = 0, extSel = 0, enable = 0;
  logic [2:0] rateSel = 0;
  logic irqEn = 0, ackWr = 0, ackVal = 0, stopMode = 0, stopRunEn = 0;
  logic flag, irq;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit finished = 0;
  string curTag = "R10";

  logic [TOT-1:0] mCnt = '0;
  logic           mFlag = 1'b0;

  always #2.5 clk = ~clk;

  timebase_irq #(.PRE_BITS(P), .CHAIN_BITS(C)) uut (
    .clk(clk), .rst(rst), .intTick(intTick), .extTick(extTick), .extSel(extSel),
    .enable(enable), .rateSel(rateSel), .irqEn(irqEn), .ackWr(ackWr), .ackVal(ackVal),
    .stopMode(stopMode), .stopRunEn(stopRunEn), .flag(flag), .irq(irq)
  );

  // Exponent of the division ratio per R2
  function automatic int ratioExp(input int idx);
    case (idx)
      0: return P + 3;
      1: return P + 4;
      2: return P + 5;
      3: return P + 6;
      4: return P + 7;
      5: return P + 11;
      6: return P + 13;
      default: return P + C;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // One clock: apply inputs at the edge, update the model, check at the falling edge
  task automatic step();
    logic [TOT-1:0] old;
    bit hit;
    bit tk;
    int b;
    @(posedge clk);
    if (rst) begin
      mCnt = '0;
      mFlag = 1'b0;
    end else begin
      hit = 0;
      tk = extSel ? extTick : intTick;
      if (!enable) mCnt = '0;
      else if (tk && !(stopMode && !stopRunEn)) begin
        old = mCnt;
        mCnt = mCnt + 1'b1;
        b = ratioExp(int'(rateSel)) - 1;
        hit = !old[b] && mCnt[b];
      end
      if (hit) mFlag = 1'b1;
      else if (ackWr && ackVal) mFlag = 1'b0;
    end
    @(negedge clk);
    check(flag == mFlag, {curTag, " flag"}, int'(flag), int'(mFlag));
    check(irq == (mFlag && irqEn), "R5 irq", int'(irq), int'(mFlag && irqEn));
  endtask

  task automatic clearAndZero();
    enable = 0; ackWr = 1; ackVal = 1; intTick = 1; extSel = 0;
    stopMode = 0; stopRunEn = 0;
    step();
    ackWr = 0; ackVal = 0;
  endtask

  // Count steps from enable until the flag rises
  task automatic stepsToFlag(output int n, input int limit);
    n = 0;
    do begin
      step();
      n++;
    end while (!flag && n < limit);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    @(negedge clk);
    step();
    step();
    check(flag == 0 && irq == 0, "R10 reset state", int'(flag), 0);
    rst = 0;

    // R1: ticking while disabled raises nothing
    curTag = "R1";
    intTick = 1;
    for (int i = 0; i < 64; i++) step();
    check(flag == 0, "R1 disabled no flag", int'(flag), 0);

    // R2 R3: first event at half period on every tap
    for (int idx = 0; idx < 8; idx++) begin
      curTag = "R3";
      clearAndZero();
      rateSel = 3'(idx); enable = 1;
      stepsToFlag(n, 40000);
      check(n == (1 << (ratioExp(idx) - 1)), $sformatf("R2 R3 first event tap %0d", idx),
            n, 1 << (ratioExp(idx) - 1));
      if (idx < 5) begin
        // R4: full period after the first event, ack in the first cycle
        curTag = "R4";
        ackWr = 1; ackVal = 1;
        step();
        ackWr = 0; ackVal = 0;
        stepsToFlag(n, 4000);
        check(n + 1 == (1 << ratioExp(idx)), $sformatf("R4 period tap %0d", idx),
              n + 1, 1 << ratioExp(idx));
      end
    end

    // R6: writing zero keeps the flag, writing one clears it
    curTag = "R6";
    intTick = 0;
    ackWr = 1; ackVal = 0; step();
    check(flag == 1, "R6 write zero keeps flag", int'(flag), 1);
    ackVal = 1; step();
    ackWr = 0; ackVal = 0;
    check(flag == 0, "R6 write one clears flag", int'(flag), 0);

    // R7: event and acknowledge in the same cycle
    curTag = "R7";
    clearAndZero();
    rateSel = 0; enable = 1; intTick = 1;
    for (int i = 0; i < (1 << (ratioExp(0) - 1)) - 1; i++) step();
    ackWr = 1; ackVal = 1; step();
    ackWr = 0; ackVal = 0;
    check(flag == 1, "R7 event wins over ack", int'(flag), 1);

    // R11: rate change without counter reset
    curTag = "R11";
    clearAndZero();
    rateSel = 1; enable = 1; intTick = 1;
    for (int i = 0; i < 10; i++) step();
    rateSel = 0;
    stepsToFlag(n, 100);
    check(n == 14, "R11 rate change keeps count", n, 14);

    // R8: select the external tick, internal ticks ignored
    curTag = "R8";
    clearAndZero();
    extSel = 1; intTick = 1; extTick = 0; rateSel = 0; enable = 1;
    for (int i = 0; i < 40; i++) step();
    check(flag == 0, "R8 internal ignored when external selected", int'(flag), 0);
    extTick = 1;
    stepsToFlag(n, 100);
    check(n == (1 << (ratioExp(0) - 1)), "R8 external drives count", n, 1 << (ratioExp(0) - 1));

    // R9: frozen in stop unless allowed
    curTag = "R9";
    clearAndZero();
    rateSel = 0; enable = 1; intTick = 1;
    for (int i = 0; i < 5; i++) step();
    stopMode = 1; stopRunEn = 0;
    for (int i = 0; i < 50; i++) step();
    check(flag == 0, "R9 frozen in stop", int'(flag), 0);
    stopMode = 0;
    stepsToFlag(n, 100);
    check(n == (1 << (ratioExp(0) - 1)) - 5, "R9 resumes from held count", n,
          (1 << (ratioExp(0) - 1)) - 5);
    clearAndZero();
    enable = 1; stopMode = 1; stopRunEn = 1;
    stepsToFlag(n, 100);
    check(n == (1 << (ratioExp(0) - 1)), "R9 runs in stop when allowed", n, 1 << (ratioExp(0) - 1));

    // Random mix checked every cycle against the model
    curTag = "R4";
    stopMode = 0; stopRunEn = 0; enable = 1;
    for (int i = 0; i < 6000; i++) begin
      intTick = ($urandom % 4) != 0;
      extTick = ($urandom % 3) != 0;
      ackWr = ($urandom % 16) == 0;
      ackVal = $urandom % 2;
      irqEn = $urandom % 2;
      if ($urandom % 200 == 0) extSel = $urandom % 2;
      if ($urandom % 150 == 0) rateSel = 3'($urandom % 3);
      if ($urandom % 500 == 0) enable = ~enable;
      if ($urandom % 300 == 0) begin stopMode = $urandom % 2; stopRunEn = $urandom % 2; end
      step();
    end

    finish();
  end

endmodule